// File: doc/BRIEF.md
# Four-Point QAM Digital Transmitter

This block builds a four-point quadrature amplitude modulated waveform entirely in logic and presents it as one signed sample per clock for a DAC. A counter divides the sample clock down to the symbol rate. On each symbol boundary a linear feedback shift register supplies a fresh pseudo-random two-bit symbol. A mapper turns the symbol into a pair of signed unit levels, and these levels stay fixed for the whole symbol period with no pulse shaping.

A phase accumulator with a run-time tuning word addresses a quarter-wave sine table, which yields a sine and a cosine carrier. The mixer weights the cosine by the in-phase level and the sine by the quadrature level, then adds the two products. The output sample is registered and travels with a valid flag that stays high once reset is released. For a second DAC channel the block also provides a symbol-rate strobe and a square wave that toggles on every symbol boundary. Both serve as a timing reference.

Top module: `qam4_tx`

## Requirements
- R1: While `rst_n` is low, `smp_valid` is 0, `smp_data` is 0, `sym_tick` is 0, `sym_square` is 0 and the current symbol is 00, so `lvl_i` and `lvl_q` both read +1.
- R2: `smp_valid` rises at the first rising clock edge after reset is released and then stays high.
- R3: `sym_tick` is a one-cycle pulse. It is high after every SYM_PERIOD-th clock edge since reset (edge counts SYM_PERIOD-1, 2·SYM_PERIOD-1, …) and low otherwise.
- R4: The symbol changes only on the edge where `sym_tick` is high. The new value is the two low bits of the next state of a 16-bit right-shifting Galois LFSR. The LFSR starts at seed 0xACE1 and advances as next = (s >> 1) XOR (s[0] ? 0xB400 : 0).
- R5: The mapping is symbol 00 → (I=+1, Q=+1), 01 → (+1, −1), 10 → (−1, −1), 11 → (−1, +1). `lvl_i` and `lvl_q` carry the levels as 2-bit two's complement, with 01 for +1 and 11 for −1.
- R6: `sym_square` inverts on every edge where `sym_tick` is high and holds its value on all other edges.
- R7: The carrier phase starts at 0 after reset and advances by `tune_word` on every clock. Phase 0 is cosine peak / sine zero, and a quarter of the phase range is 90 degrees.
- R8: The sample registered at clock edge k equals I·cos(φ) + Q·sin(φ). Here I and Q are the levels of the symbol in force before that edge, φ = (k−1)·`tune_word`, and the carrier peak is A = 2^(SAMPLE_W−2)−1.
- R9: The sample magnitude never exceeds 2·A, so the sum cannot wrap.
- R10: With `tune_word` = 0 the output is constant within each symbol and equals I·A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tune_word | input | PHASE_W | Phase increment added each cycle |
| smp_valid | output | 1 | Sample stream valid flag |
| smp_data | output | SAMPLE_W | Signed modulated sample |
| sym_tick | output | 1 | One-cycle symbol boundary strobe |
| sym_square | output | 1 | Square wave at half the symbol rate, toggling per symbol |
| lvl_i | output | 2 | Current in-phase level (signed) |
| lvl_q | output | 2 | Current quadrature level (signed) |

## Verification
The overflow property assumes the table peak is no larger than A, which holds for any legal SAMPLE_W. The period property counts edges from reset, so it presumes that the reset is asynchronous and that no other event restarts the counter. The exact sample values used as expectations are exact only when the carrier lands on a multiple of 90 degrees. For that reason the stimulus uses tuning words of 0, a quarter and a half of the phase range, and it holds each word constant between resets so that the phase is known from the edge count.

// File: rtl/qam4_pkg.sv
package qam4_pkg;

   localparam logic signed [1:0] LVL_POS = 2'sb01;
   localparam logic signed [1:0] LVL_NEG = 2'sb11;

   typedef struct packed {
      logic signed [1:0] i;
      logic signed [1:0] q;
   } iq_lvl_t;

   // square constellation walked in symbol order
   function automatic iq_lvl_t map_symbol(input logic [1:0] sym);
      iq_lvl_t r;
      r.i = sym[1] ? LVL_NEG : LVL_POS;
      r.q = (sym[1] ^ sym[0]) ? LVL_NEG : LVL_POS;
      return r;
   endfunction

endpackage

// File: rtl/qam4_tick_gen.sv
module qam4_tick_gen #(
   parameter int SYM_PERIOD = 120
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   localparam int CNT_W = (SYM_PERIOD > 2) ? $clog2(SYM_PERIOD) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_PERIOD - 1);

   logic [CNT_W-1:0] cnt;

   assign tick = (cnt == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (tick) cnt <= '0;
      else           cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/qam4_symsrc.sv
module qam4_symsrc #(
   parameter int          LFSR_W    = 16,
   parameter int unsigned LFSR_TAPS = 32'h0000_B400,
   parameter int unsigned LFSR_SEED = 32'h0000_ACE1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   output logic [1:0] sym,
   output logic       square
);
   localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(LFSR_TAPS);
   localparam logic [LFSR_W-1:0] SEED = LFSR_W'(LFSR_SEED);

   logic [LFSR_W-1:0] state;
   logic [LFSR_W-1:0] state_nxt;

   assign state_nxt = (state >> 1) ^ (state[0] ? TAPS : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEED;
         sym    <= 2'b00;
         square <= 1'b0;
      end else if (tick) begin
         state  <= state_nxt;
         sym    <= state_nxt[1:0];
         square <= ~square;
      end
   end
endmodule

// File: rtl/qam4_sine_rom.sv
module qam4_sine_rom #(
   parameter int TBL_AW = 6,
   parameter int MAG_W  = 12,
   parameter int AMP    = 4095
) (
   input  logic [TBL_AW+1:0]      idx,
   output logic signed [MAG_W:0]  val
);
   localparam int N = 1 << TBL_AW;

   logic [MAG_W-1:0] tbl [0:N];

   // N+1 points span 0..90 degrees inclusive, so both the zero and the peak are exact
   for (genvar k = 0; k <= N; k++) begin : g_tbl
      localparam real ANG = 1.5707963267948966 * real'(k) / real'(N);
      localparam int  VAL = $rtoi(real'(AMP) * $sin(ANG) + 0.5);
      assign tbl[k] = MAG_W'(VAL);
   end

   logic [1:0]        quad;
   logic [TBL_AW-1:0] ofs;
   logic [TBL_AW:0]   addr;
   logic [MAG_W-1:0]  mag;

   always_comb begin
      quad = idx[TBL_AW+1:TBL_AW];
      ofs  = idx[TBL_AW-1:0];
      addr = quad[0] ? ((TBL_AW+1)'(N) - {1'b0, ofs}) : {1'b0, ofs};
      mag  = tbl[addr];
      val  = quad[1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
   end
endmodule

// File: rtl/qam4_dds.sv
module qam4_dds #(
   parameter int PHASE_W = 24,
   parameter int TBL_AW  = 6,
   parameter int MAG_W   = 12,
   parameter int AMP     = 4095
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [PHASE_W-1:0]   tune_word,
   output logic signed [MAG_W:0] car_cos,
   output logic signed [MAG_W:0] car_sin
);
   localparam int IDX_W = TBL_AW + 2;
   localparam logic [IDX_W-1:0] QUARTER = IDX_W'(1 << TBL_AW);

   logic [PHASE_W-1:0]   acc;
   logic [IDX_W-1:0]     idx [2];
   logic signed [MAG_W:0] val [2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) acc <= '0;
      else        acc <= acc + tune_word;
   end

   assign idx[0] = acc[PHASE_W-1 -: IDX_W];
   assign idx[1] = acc[PHASE_W-1 -: IDX_W] + QUARTER;

   for (genvar c = 0; c < 2; c++) begin : g_rom
      qam4_sine_rom #(
         .TBL_AW (TBL_AW),
         .MAG_W  (MAG_W),
         .AMP    (AMP)
      ) rom_i (
         .idx (idx[c]),
         .val (val[c])
      );
   end

   assign car_sin = val[0];
   assign car_cos = val[1];
endmodule

// File: rtl/qam4_mixer.sv
module qam4_mixer #(
   parameter int SAMPLE_W = 14,
   parameter bit USE_MULT = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic signed [1:0]            lvl_i,
   input  logic signed [1:0]            lvl_q,
   input  logic signed [SAMPLE_W-2:0]   car_cos,
   input  logic signed [SAMPLE_W-2:0]   car_sin,
   output logic                         valid,
   output logic signed [SAMPLE_W-1:0]   sample
);
   logic signed [SAMPLE_W-1:0] cos_x, sin_x, p_i, p_q;

   assign cos_x = SAMPLE_W'(car_cos);
   assign sin_x = SAMPLE_W'(car_sin);

   if (USE_MULT) begin : g_mult
      assign p_i = SAMPLE_W'(lvl_i) * cos_x;
      assign p_q = SAMPLE_W'(lvl_q) * sin_x;
   end else begin : g_negate
      assign p_i = lvl_i[1] ? -cos_x : cos_x;
      assign p_q = lvl_q[1] ? -sin_x : sin_x;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         sample <= '0;
      end else begin
         valid  <= 1'b1;
         sample <= p_i + p_q;
      end
   end
endmodule

// File: rtl/qam4_tx.sv
module qam4_tx
   import qam4_pkg::*;
#(
   parameter int          SAMPLE_W   = 14,
   parameter int          PHASE_W    = 24,
   parameter int          TBL_AW     = 6,
   parameter int          SYM_PERIOD = 120,
   parameter int          LFSR_W     = 16,
   parameter int unsigned LFSR_TAPS  = 32'h0000_B400,
   parameter int unsigned LFSR_SEED  = 32'h0000_ACE1,
   parameter bit          USE_MULT   = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [PHASE_W-1:0]         tune_word,
   output logic                       smp_valid,
   output logic signed [SAMPLE_W-1:0] smp_data,
   output logic                       sym_tick,
   output logic                       sym_square,
   output logic signed [1:0]          lvl_i,
   output logic signed [1:0]          lvl_q
);
   localparam int MAG_W = SAMPLE_W - 2;
   localparam int AMP   = (1 << MAG_W) - 1;

   if (SAMPLE_W < 4 || SAMPLE_W > 24) begin : g_bad_sw
      $error("qam4_tx: SAMPLE_W out of range");
   end
   if (SYM_PERIOD < 2) begin : g_bad_sp
      $error("qam4_tx: SYM_PERIOD must be at least 2");
   end
   if (TBL_AW < 2 || TBL_AW > 10) begin : g_bad_aw
      $error("qam4_tx: TBL_AW out of range");
   end
   if (PHASE_W < TBL_AW + 2) begin : g_bad_pw
      $error("qam4_tx: PHASE_W too narrow for table");
   end
   if (LFSR_W < 3 || LFSR_W > 32 || LFSR_SEED == 0) begin : g_bad_lfsr
      $error("qam4_tx: bad LFSR width or zero seed");
   end

   logic       tick;
   logic [1:0] sym;
   iq_lvl_t    lvl;
   logic signed [MAG_W:0] car_cos, car_sin;

   qam4_tick_gen #(.SYM_PERIOD(SYM_PERIOD)) tick_i (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick)
   );

   qam4_symsrc #(
      .LFSR_W    (LFSR_W),
      .LFSR_TAPS (LFSR_TAPS),
      .LFSR_SEED (LFSR_SEED)
   ) src_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .sym    (sym),
      .square (sym_square)
   );

   assign lvl = map_symbol(sym);

   qam4_dds #(
      .PHASE_W (PHASE_W),
      .TBL_AW  (TBL_AW),
      .MAG_W   (MAG_W),
      .AMP     (AMP)
   ) dds_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tune_word (tune_word),
      .car_cos   (car_cos),
      .car_sin   (car_sin)
   );

   qam4_mixer #(
      .SAMPLE_W (SAMPLE_W),
      .USE_MULT (USE_MULT)
   ) mix_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl_i   (lvl.i),
      .lvl_q   (lvl.q),
      .car_cos (car_cos),
      .car_sin (car_sin),
      .valid   (smp_valid),
      .sample  (smp_data)
   );

   assign sym_tick = tick;
   assign lvl_i    = lvl.i;
   assign lvl_q    = lvl.q;
endmodule

// File: rtl/qam4_tx_chk.sv
module qam4_tx_chk #(
   parameter int SAMPLE_W   = 14,
   parameter int SYM_PERIOD = 120
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       smp_valid,
   input logic signed [SAMPLE_W-1:0] smp_data,
   input logic                       sym_tick,
   input logic                       sym_square,
   input logic signed [1:0]          lvl_i,
   input logic signed [1:0]          lvl_q
);
   localparam int LIM = 2 * ((1 << (SAMPLE_W - 2)) - 1);

   int gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap <= 0;
      else if (sym_tick) gap <= 0;
      else               gap <= gap + 1;
   end

   AST_VALID_STICKY: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |=> smp_valid); // R2
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) sym_tick |=> !sym_tick); // R3
   AST_TICK_PERIOD: assert property (@(posedge clk) disable iff (!rst_n) sym_tick |-> gap == SYM_PERIOD - 1); // R3
   AST_SYM_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sym_tick |=> $stable(lvl_i) && $stable(lvl_q)); // R4
   AST_LVL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) (lvl_i == 2'sb01 || lvl_i == 2'sb11) && (lvl_q == 2'sb01 || lvl_q == 2'sb11)); // R5
   AST_SQ_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n) sym_tick |=> sym_square != $past(sym_square)); // R6
   AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !sym_tick |=> $stable(sym_square)); // R6
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) smp_data <= LIM && smp_data >= -LIM); // R9
endmodule

bind qam4_tx qam4_tx_chk #(
   .SAMPLE_W   (SAMPLE_W),
   .SYM_PERIOD (SYM_PERIOD)
) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .smp_data   (smp_data),
   .sym_tick   (sym_tick),
   .sym_square (sym_square),
   .lvl_i      (lvl_i),
   .lvl_q      (lvl_q)
);

// File: tb/qam4_tx_tb_top.sv
module qam4_tx_tb_top;
   localparam int SW  = 14;
   localparam int PW  = 16;
   localparam int P   = 8;
   localparam int AMP = (1 << (SW - 2)) - 1;
   localparam logic [PW-1:0] QTR  = PW'(1 << (PW - 2));
   localparam logic [PW-1:0] HALF = PW'(1 << (PW - 1));

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [PW-1:0]        tune_word = '0;
   logic                 smp_valid;
   logic signed [SW-1:0] smp_data;
   logic                 sym_tick;
   logic                 sym_square;
   logic signed [1:0]    lvl_i;
   logic signed [1:0]    lvl_q;

   int n_vec  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   qam4_tx #(
      .SAMPLE_W   (SW),
      .PHASE_W    (PW),
      .TBL_AW     (6),
      .SYM_PERIOD (P),
      .LFSR_W     (16),
      .LFSR_TAPS  (32'h0000_B400),
      .LFSR_SEED  (32'h0000_ACE1),
      .USE_MULT   (1'b1)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tune_word  (tune_word),
      .smp_valid  (smp_valid),
      .smp_data   (smp_data),
      .sym_tick   (sym_tick),
      .sym_square (sym_square),
      .lvl_i      (lvl_i),
      .lvl_q      (lvl_q)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int lvl_of(input logic [1:0] s, input bit q);
      // R5 table, written independently
      case (s)
         2'b00: return 1;
         2'b01: return q ? -1 : 1;
         2'b10: return -1;
         default: return q ? 1 : -1;
      endcase
   endfunction

   task automatic do_reset(input logic [PW-1:0] tw);
      @(negedge clk);
      rst_n = 1'b0;
      tune_word = tw;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // resets, then steps n_sym symbols comparing every output each cycle
   task automatic run_stream(input logic [PW-1:0] tw, input int n_sym, input bit exp_const,
                             output int seen_mask);
      logic [15:0]   m_lfsr = 16'hACE1;
      logic [1:0]    m_sym  = 2'b00;
      logic [1:0]    prev;
      logic [PW-1:0] m_ph   = '0;
      int cs, sn, ie, qe, hold;
      seen_mask = 1;
      hold = 0;
      do_reset(tw);
      for (int k = 1; k <= n_sym * P; k++) begin
         @(posedge clk);
         @(negedge clk);
         prev = m_sym;
         if (k % P == 0) begin
            m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0000);
            m_sym  = m_lfsr[1:0];
            seen_mask |= (1 << m_sym);
         end
         case (m_ph[PW-1:PW-2])
            2'd0: begin cs = AMP; sn = 0; end
            2'd1: begin cs = 0;   sn = AMP; end
            2'd2: begin cs = -AMP; sn = 0; end
            default: begin cs = 0; sn = -AMP; end
         endcase
         m_ph = m_ph + tw;
         ie = lvl_of(prev, 1'b0);
         qe = lvl_of(prev, 1'b1);
         chk("R2 valid", int'(smp_valid), 1);
         chk("R3 tick", int'(sym_tick), (k % P == P - 1) ? 1 : 0);
         chk("R6 square", int'(sym_square), (k / P) % 2);
         chk("R4/R5 lvl_i", int'(lvl_i), lvl_of(m_sym, 1'b0));
         chk("R4/R5 lvl_q", int'(lvl_q), lvl_of(m_sym, 1'b1));
         chk("R7/R8 sample", int'(smp_data), ie * cs + qe * sn);
         if (int'(smp_data) > 2 * AMP || int'(smp_data) < -2 * AMP)
            chk("R9 range", int'(smp_data), 2 * AMP);
         if (exp_const) begin
            if (k > 1 && (k - 1) % P != 0) chk("R10 constant", int'(smp_data), hold);
            hold = int'(smp_data);
         end
      end
   endtask

   task automatic t_reset_state;
      do_reset(QTR);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 valid", int'(smp_valid), 0);
      chk("R1 sample", int'(smp_data), 0);
      chk("R1 tick", int'(sym_tick), 0);
      chk("R1 square", int'(sym_square), 0);
      chk("R1 lvl_i", int'(lvl_i), 1);
      chk("R1 lvl_q", int'(lvl_q), 1);
   endtask

   task automatic t_still_carrier;
      int seen;
      run_stream('0, 20, 1'b1, seen);
      chk("R5 all four symbols seen", seen, 15);
   endtask

   task automatic t_quarter_step;
      int seen;
      run_stream(QTR, 12, 1'b0, seen);
   endtask

   task automatic t_half_step;
      int seen;
      run_stream(HALF, 12, 1'b0, seen);
   endtask

   task automatic t_first_sample;
      // R2 and R8: first sample after reset comes from phase 0 with symbol 00 -> A
      do_reset(QTR);
      #1;
      chk("R2 valid low before first edge", int'(smp_valid), 0);
      @(posedge clk);
      @(negedge clk);
      chk("R2 valid first edge", int'(smp_valid), 1);
      chk("R8 first sample", int'(smp_data), AMP);
   endtask

   task automatic finish_run;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      t_reset_state();
      t_first_sample();
      t_still_carrier();
      t_quarter_step();
      t_half_step();
      finish_run();
   end
endmodule